// File: doc/BRIEF.md
# Signed/Unsigned Integer Divide-Modulo Unit

This block is a multi-cycle integer divider for a virtual instruction set of the packet-filter kind. A single `start` strobe hands it a destination operand (the dividend) and a source operand (the divisor). It then returns either the quotient or the remainder on `result`, together with a one-cycle `done` pulse. It works in 32-bit or 64-bit mode. The instruction's offset field picks the signedness: a zero offset means unsigned, and any other value means signed.

Inside, the unit takes the magnitudes of both operands. It then runs a radix-2 restoring divider, one cycle per result bit (32 or 64 steps), and corrects the signs in a final cycle. Signed remainders follow truncated division, so a remainder always carries the sign of the dividend. A zero divisor and the most-negative-by-minus-one case both have defined results and never trap. While an operation is in flight, `busy` is high and any new `start` is dropped.

Top module: `divmod_unit`

## Requirements
- R1: With `op_offset` equal to zero, both operands are treated as unsigned; for example, 0xFFFFFFFFFFFFFFFF / 2 in 64-bit mode gives 0x7FFFFFFFFFFFFFFF.
- R2: With any non-zero `op_offset`, both operands are treated as two's-complement signed values and the quotient is truncated toward zero; for example, -13 / 3 gives -4.
- R3: A signed remainder satisfies a - n*trunc(a/n), so it takes the sign of the dividend: -13 mod 3 = -1, 13 mod -3 = 1, -13 mod -3 = -1.
- R4: With `mode64` low, only bits 31:0 of each operand are used, and bits 63:32 of `result` are zero.
- R5: With `mode64` high, the same operations act on the full 64-bit operands.
- R6: A zero divisor (after masking to the mode width) gives a quotient of 0. For modulo it returns the dividend unchanged, still masked to 32 bits in 32-bit mode.
- R7: The most negative dividend divided by -1, signed, gives the most negative value as quotient and 0 as remainder. The 32-bit case gives 0x0000000080000000.
- R8: A `start` sampled while `busy` is low is accepted. `busy` is high from the next cycle on, and `done` rises 33 clock edges after the accepting edge in 32-bit mode and 65 in 64-bit mode. `busy` is low whenever `done` is high.
- R9: `done` stays high for exactly one cycle per accepted operation. `result` holds its value until the next completion.
- R10: A `start` while `busy` is high is ignored. The running operation completes with its original operands and no extra completion follows.
- R11: After a synchronous reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation when not busy |
| mode64 | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| want_rem | input | 1 | 1 = remainder, 0 = quotient |
| op_offset | input | 16 | Offset field; non-zero selects signed arithmetic |
| dst_val | input | 64 | Dividend |
| src_val | input | 64 | Divisor |
| busy | output | 1 | Operation in flight; starts are ignored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient or remainder of the last completed operation |

## Verification
The assertions assume that `start` and the operand inputs are known values at every clock edge after reset. They also assume that `rst` is held for at least one edge before the first check. The bench changes inputs only on falling edges and waits for `busy` to drop before it starts a new operation. The one exception is the deliberate overlapping start used to show that a busy unit ignores it. In that test the operands are changed on purpose, so that taking them in would show up as a wrong result.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    // Per-operation side information carried from acceptance to completion
    typedef struct packed {
        logic            is64;
        logic            want_rem;
        logic            neg_quo;
        logic            neg_rem;
        logic            div_zero;
        logic [XLEN-1:0] dividend;
    } op_info_t;

    // Sign bit of a value in the current mode
    function automatic logic sign_of(input logic [XLEN-1:0] v, input logic is64);
        return is64 ? v[XLEN-1] : v[HALF-1];
    endfunction

    // Value masked to the mode width (upper half cleared in 32-bit mode)
    function automatic logic [XLEN-1:0] fit_width(input logic [XLEN-1:0] v, input logic is64);
        return is64 ? v : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    // Magnitude of a mode-width value; negate when flagged negative
    function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v,
                                                  input logic is64,
                                                  input logic neg);
        logic [XLEN-1:0] ext;
        ext = is64 ? v : {{HALF{v[HALF-1]}}, v[HALF-1:0]};
        return neg ? fit_width(-ext, is64) : fit_width(v, is64);
    endfunction

endpackage

// File: rtl/divmod_prep.sv
module divmod_prep
    import divmod_pkg::*;
#(
    parameter int OFFW = 16
) (
    input  logic            is64,
    input  logic            want_rem,
    input  logic [OFFW-1:0] offset,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    output logic [XLEN-1:0] a_mag,
    output logic [XLEN-1:0] b_mag,
    output op_info_t        info
);
    logic is_signed;
    logic sa;
    logic sb;

    always_comb begin
        is_signed     = |offset;
        sa            = is_signed & sign_of(dst_val, is64);
        sb            = is_signed & sign_of(src_val, is64);
        a_mag         = magnitude(dst_val, is64, sa);
        b_mag         = magnitude(src_val, is64, sb);
        info.is64     = is64;
        info.want_rem = want_rem;
        info.neg_quo  = sa ^ sb;
        info.neg_rem  = sa;
        info.div_zero = (fit_width(src_val, is64) == '0);
        info.dividend = fit_width(dst_val, is64);
    end
endmodule

// File: rtl/divmod_core.sv
module divmod_core
    import divmod_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is64,
    input  logic [XLEN-1:0] a_mag,
    input  logic [XLEN-1:0] b_mag,
    output logic            accept,
    output logic            busy,
    output logic            fin,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    localparam int CW = $clog2(XLEN);

    div_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] dvs_q;
    logic [XLEN:0]   trial;
    logic [XLEN:0]   diff;

    assign busy   = (state_q != ST_IDLE);
    assign accept = start && !busy;
    assign fin    = (state_q == ST_FIN);
    assign quo    = quo_q;
    assign rem    = rem_q;

    always_comb begin
        trial = {rem_q, quo_q[XLEN-1]};
        diff  = trial - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    quo_q   <= is64 ? a_mag : (a_mag << HALF);
                    rem_q   <= '0;
                    dvs_q   <= b_mag;
                    cnt_q   <= is64 ? CW'(XLEN - 1) : CW'(HALF - 1);
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (!diff[XLEN]) begin
                        rem_q <= diff[XLEN-1:0];
                        quo_q <= {quo_q[XLEN-2:0], 1'b1};
                    end else begin
                        rem_q <= trial[XLEN-1:0];
                        quo_q <= {quo_q[XLEN-2:0], 1'b0};
                    end
                    if (cnt_q == '0) state_q <= ST_FIN;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: a start while busy must not disturb the latched divisor
    p_busy_holds_divisor_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(dvs_q));

    // R3: restoring iteration leaves a remainder magnitude below the divisor
    p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (rst)
        (fin && dvs_q != '0) |-> (rem_q < dvs_q));

    // R8: an accepted start makes the unit busy on the next cycle
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
endmodule

// File: rtl/divmod_fixup.sv
module divmod_fixup
    import divmod_pkg::*;
(
    input  op_info_t        info,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] q_s;
    logic [XLEN-1:0] r_s;
    logic [XLEN-1:0] pick;

    always_comb begin
        q_s = info.neg_quo ? -quo : quo;
        r_s = info.neg_rem ? -rem : rem;
        if (info.div_zero) pick = info.want_rem ? info.dividend : '0;
        else               pick = info.want_rem ? r_s : q_s;
        res = fit_width(pick, info.is64);
    end
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
    import divmod_pkg::*;
#(
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            mode64,
    input  logic            want_rem,
    input  logic [OFFW-1:0] op_offset,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] a_mag;
    logic [XLEN-1:0] b_mag;
    op_info_t        info_c;
    op_info_t        info_q;
    logic            accept;
    logic            fin;
    logic [XLEN-1:0] quo;
    logic [XLEN-1:0] rem;
    logic [XLEN-1:0] res_c;
    logic            done_q;
    logic [XLEN-1:0] result_q;

    divmod_prep #(.OFFW(OFFW)) u_prep (
        .is64     (mode64),
        .want_rem (want_rem),
        .offset   (op_offset),
        .dst_val  (dst_val),
        .src_val  (src_val),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .info     (info_c)
    );

    divmod_core u_core (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .is64   (mode64),
        .a_mag  (a_mag),
        .b_mag  (b_mag),
        .accept (accept),
        .busy   (busy),
        .fin    (fin),
        .quo    (quo),
        .rem    (rem)
    );

    divmod_fixup u_fixup (
        .info (info_q),
        .quo  (quo),
        .rem  (rem),
        .res  (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q   <= '0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            if (accept) info_q <= info_c;
            done_q <= fin;
            if (fin) result_q <= res_c;
        end
    end

    assign done   = done_q;
    assign result = result_q;

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: the unit is idle when it reports completion
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4: a 32-bit operation never sets the upper result half
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !info_q.is64) |-> (result[XLEN-1:HALF] == '0));

    // R6: division by zero yields a zero quotient
    p_zero_div_quot_r6: assert property (@(posedge clk) disable iff (rst)
        (done && info_q.div_zero && !info_q.want_rem) |-> (result == '0));

    // R9: result is held between completions
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(result)));
endmodule

// File: tb/test_divmod_unit.sv
module test_divmod_unit;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          mode64;
    logic          want_rem;
    logic [15:0]   op_offset;
    logic [W-1:0]  dst_val;
    logic [W-1:0]  src_val;
    logic          busy;
    logic          done;
    logic [W-1:0]  result;

    int n_tests = 0;
    int n_fail  = 0;
    int got_lat;

    always #2 clk = ~clk;   // 250 MHz

    divmod_unit i_divmod_unit (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode64    (mode64),
        .want_rem  (want_rem),
        .op_offset (op_offset),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    typedef struct packed {
        logic         is64;
        logic         rem;
        logic [15:0]  off;
        logic [63:0]  a;
        logic [63:0]  b;
        logic [63:0]  exp;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 64'd100, 64'd7, 64'd14, 8'd1},                                        // R1
        '{1'b0, 1'b1, 16'h0000, 64'd100, 64'd7, 64'd2, 8'd1},                                         // R1
        '{1'b0, 1'b0, 16'h0001, 64'hDEADBEEF_FFFFFFF3, 64'd3, 64'h00000000_FFFFFFFC, 8'd2},           // R2 R4
        '{1'b0, 1'b1, 16'h0001, 64'hDEADBEEF_FFFFFFF3, 64'd3, 64'h00000000_FFFFFFFF, 8'd3},           // R3
        '{1'b0, 1'b0, 16'h0000, 64'hDEADBEEF_FFFFFFF3, 64'd3, 64'h00000000_55555551, 8'd4},           // R1 R4
        '{1'b1, 1'b0, 16'h0001, 64'hFFFFFFFF_FFFFFFF3, 64'd3, 64'hFFFFFFFF_FFFFFFFC, 8'd5},           // R5 R2
        '{1'b1, 1'b1, 16'hFFFF, 64'd13, 64'hFFFFFFFF_FFFFFFFD, 64'd1, 8'd3},                          // R3
        '{1'b1, 1'b1, 16'h0001, 64'hFFFFFFFF_FFFFFFF3, 64'hFFFFFFFF_FFFFFFFD, 64'hFFFFFFFF_FFFFFFFF, 8'd3}, // R3
        '{1'b1, 1'b0, 16'h0000, 64'hFFFFFFFF_FFFFFFFF, 64'd2, 64'h7FFFFFFF_FFFFFFFF, 8'd1},           // R1 R5
        '{1'b1, 1'b0, 16'h0001, 64'h80000000_00000000, 64'hFFFFFFFF_FFFFFFFF, 64'h80000000_00000000, 8'd7}, // R7
        '{1'b1, 1'b1, 16'h0001, 64'h80000000_00000000, 64'hFFFFFFFF_FFFFFFFF, 64'd0, 8'd7},           // R7
        '{1'b0, 1'b0, 16'h0001, 64'h12345678_80000000, 64'h00000000_FFFFFFFF, 64'h00000000_80000000, 8'd7}, // R7 R4
        '{1'b1, 1'b0, 16'h0000, 64'd123, 64'd0, 64'd0, 8'd6},                                         // R6
        '{1'b1, 1'b1, 16'h0001, 64'hFFFFFFFF_FFFFFFFB, 64'd0, 64'hFFFFFFFF_FFFFFFFB, 8'd6},           // R6
        '{1'b0, 1'b1, 16'h0000, 64'hAAAAAAAA_12345678, 64'hFFFFFFFF_00000000, 64'h00000000_12345678, 8'd6}, // R6 R4
        '{1'b0, 1'b0, 16'h0001, 64'hAAAAAAAA_12345678, 64'hFFFFFFFF_00000000, 64'd0, 8'd6},           // R6
        '{1'b1, 1'b0, 16'h0000, 64'h01234567_89ABCDEF, 64'h100, 64'h00012345_6789ABCD, 8'd5},         // R5
        '{1'b1, 1'b1, 16'h0000, 64'h01234567_89ABCDEF, 64'h100, 64'hEF, 8'd5},                        // R5
        '{1'b1, 1'b0, 16'h0001, 64'hFFFFFFFF_FFFFFF9C, 64'd7, 64'hFFFFFFFF_FFFFFFF2, 8'd2}            // R2
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation and wait for done; returns latency in edges
    task automatic run_op(input logic m64, input logic rm, input logic [15:0] off,
                          input logic [W-1:0] a, input logic [W-1:0] b, output int lat);
        @(negedge clk);
        while (busy) @(negedge clk);
        mode64 = m64; want_rem = rm; op_offset = off; dst_val = a; src_val = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        start = 0; mode64 = 0; want_rem = 0; op_offset = 0; dst_val = 0; src_val = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", {63'd0, busy}, 64'd0);
        check("R11 done", {63'd0, done}, 64'd0);
        check("R11 result", result, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].is64, VEC[i].rem, VEC[i].off, VEC[i].a, VEC[i].b, got_lat);
            check($sformatf("R%0d vec %0d", VEC[i].req, i), result, VEC[i].exp);
        end

        // R8: latency and busy in 32-bit mode
        run_op(1'b0, 1'b0, 16'h0, 64'd50, 64'd5, got_lat);
        check("R8 latency32", 64'(got_lat), 64'd34);
        check("R8 busy low at done", {63'd0, busy}, 64'd0);
        // R9: done lasts one cycle, result holds
        @(negedge clk);
        check("R9 done falls", {63'd0, done}, 64'd0);
        check("R9 result held", result, 64'd10);

        // R8: latency in 64-bit mode, busy right after start
        @(negedge clk);
        mode64 = 1; want_rem = 0; op_offset = 0; dst_val = 64'd1000; src_val = 64'd10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", {63'd0, busy}, 64'd1);
        // R10: overlapping start with different operands is ignored
        mode64 = 0; want_rem = 1; op_offset = 1; dst_val = 64'd7; src_val = 64'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_lat = 2;
        while (!done && got_lat < 200) begin
            @(negedge clk);
            got_lat++;
        end
        check("R8 latency64", 64'(got_lat), 64'd66);
        check("R10 original operands used", result, 64'd100);
        begin
            int extra = 0;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R10 no extra completion", 64'(extra), 64'd0);
        end
        check("R10 result unchanged", result, 64'd100);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule